// File: doc/BRIEF.md
# Bus Request and Grant Handshake Controller

This block decides when an external bus master may take over the system buses from the processor, and when the processor gets them back. Each rising clock edge marks the start of one processor time state. The processor sequencer supplies a marker that is high during the last time state of every machine cycle. The external master asks for the buses with an active-low request line. The block replies with an active-low acknowledge.

While the buses are granted, the block clears the drive enables of the processor-side address, data, control and status/sync/interrupt-acknowledge drivers, so those lines float or are driven from outside. It also raises a flag that stops the refresh counter and holds the refresh strobe inactive, a flag that masks interrupt acknowledgement, and a stall flag for the processor core. The grant is taken only at a machine-cycle boundary. It is handed back in the first time state that finds the request inactive. One further time state passes before the processor runs again.

Top module: `bus_grant_ctrl`

## Requirements
- R1: After reset, the acknowledge is high (inactive), every drive enable is 1 (processor drives), and refresh hold, interrupt mask and stall are all 0.
- R2: With the processor running, a low request sampled at a clock edge where the cycle-last marker is 1 makes the acknowledge go low at that same edge, so it is visible during the next time state.
- R3: With the processor running, a low request sampled at an edge where the cycle-last marker is 0 has no effect on any output.
- R4: While granted, the request is sampled at every edge. The grant stays in force while it is low, and the cycle-last marker has no effect.
- R5: At the first edge where a granted request is found high, the acknowledge goes high.
- R6: The state that follows the release lasts exactly one time state. At its end the processor runs again (stall, refresh hold and interrupt mask go to 0). A request or cycle-last marker seen during that state is ignored.
- R7: Refresh hold and interrupt mask are 1 from the edge that grants the bus up to the edge that ends the handback state, and 0 at all other times. Stall follows the same timing.
- R8: Every bit of the address, data, control and status drive-enable vectors is 0 exactly when the acknowledge is low and 1 otherwise. The enables change at the same edge as the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge starts a time state |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_n | input | 1 | Active-low bus request from external master |
| cyc_last | input | 1 | High during the last time state of a machine cycle |
| bus_ack_n | output | 1 | Active-low bus acknowledge |
| addr_drv_en | output | ADDR_BITS | Processor address driver enables (1 = drive) |
| data_drv_en | output | DATA_BITS | Processor data driver enables (1 = drive) |
| ctrl_drv_en | output | CTRL_LINES | Read/write/memory/IO strobe driver enables |
| stat_drv_en | output | STAT_LINES | Sync, interrupt-acknowledge and status driver enables |
| refresh_hold | output | 1 | Stops refresh counter, keeps refresh strobe inactive |
| irq_mask | output | 1 | Blocks interrupt acknowledgement |
| cpu_stall | output | 1 | Holds the processor core suspended |

## Verification
Two events can fall in one cycle. The first is the release of the request while the cycle-last marker is high. The second is a new request arriving during the handback state together with a cycle-last marker. The bench provokes both, in directed sequences and by random stimulus that toggles both inputs often. A reference model in the bench decides whether a given edge grants, holds, hands back or ignores. Each cycle it is compared against the acknowledge, all four enable vectors and the three freeze flags. This confirms that the handback state never regrants and that the release never waits for a cycle boundary.

// File: rtl/bus_grant_pkg.sv
package bus_grant_pkg;

    typedef enum logic [1:0] {
        PH_RUN      = 2'd0,
        PH_HELD     = 2'd1,
        PH_HANDBACK = 2'd2
    } grant_phase_e;

    typedef struct packed {
        grant_phase_e phase;
        logic         ack_n;
        logic         released;
        logic         freeze;
    } grant_regs_t;

    localparam grant_regs_t GRANT_RESET = '{
        phase:    PH_RUN,
        ack_n:    1'b1,
        released: 1'b0,
        freeze:   1'b0
    };

endpackage

// File: rtl/bus_grant_fsm.sv
module bus_grant_fsm
    import bus_grant_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_n,
    input  logic cyc_last,
    output logic ack_n,
    output logic released,
    output logic freeze
);

    grant_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_RUN: begin
                if (cyc_last && !bus_req_n) begin
                    r_d.phase    = PH_HELD;
                    r_d.ack_n    = 1'b0;
                    r_d.released = 1'b1;
                    r_d.freeze   = 1'b1;
                end
            end
            PH_HELD: begin
                if (bus_req_n) begin
                    r_d.phase    = PH_HANDBACK;
                    r_d.ack_n    = 1'b1;
                    r_d.released = 1'b0;
                    r_d.freeze   = 1'b1;
                end
            end
            PH_HANDBACK: begin
                r_d.phase    = PH_RUN;
                r_d.ack_n    = 1'b1;
                r_d.released = 1'b0;
                r_d.freeze   = 1'b0;
            end
            default: r_d = GRANT_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= GRANT_RESET;
        else        r_q <= r_d;
    end

    assign ack_n    = r_q.ack_n;
    assign released = r_q.released;
    assign freeze   = r_q.freeze;

    // R2: a request at a cycle boundary is granted on the next state
    a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_RUN && cyc_last && !bus_req_n) |=> !ack_n);

    // R3: a request off a cycle boundary is not granted
    a_r3_no_grant_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_RUN && !cyc_last) |=> (ack_n && !freeze));

    // R4: grant persists while request stays low
    a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HELD && !bus_req_n) |=> (!ack_n && released));

    // R5: release in the first state with the request high
    a_r5_release_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HELD && bus_req_n) |=> (ack_n && !released && freeze));

    // R6: handback lasts one state and never regrants
    a_r6_single_handback: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_HANDBACK) |=> (ack_n && !freeze));

endmodule

// File: rtl/bus_drive_group.sv
module bus_drive_group #(
    parameter int LINES = 8
) (
    input  logic             released,
    output logic [LINES-1:0] drv_en
);

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        assign drv_en[gi] = ~released;
    end

endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl #(
    parameter int ADDR_BITS  = 16,
    parameter int DATA_BITS  = 8,
    parameter int CTRL_LINES = 4,
    parameter int STAT_LINES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req_n,
    input  logic                  cyc_last,
    output logic                  bus_ack_n,
    output logic [ADDR_BITS-1:0]  addr_drv_en,
    output logic [DATA_BITS-1:0]  data_drv_en,
    output logic [CTRL_LINES-1:0] ctrl_drv_en,
    output logic [STAT_LINES-1:0] stat_drv_en,
    output logic                  refresh_hold,
    output logic                  irq_mask,
    output logic                  cpu_stall
);

    logic released;
    logic freeze;

    bus_grant_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req_n (bus_req_n),
        .cyc_last  (cyc_last),
        .ack_n     (bus_ack_n),
        .released  (released),
        .freeze    (freeze)
    );

    bus_drive_group #(.LINES(ADDR_BITS)) u_addr (
        .released (released), .drv_en (addr_drv_en));
    bus_drive_group #(.LINES(DATA_BITS)) u_data (
        .released (released), .drv_en (data_drv_en));
    bus_drive_group #(.LINES(CTRL_LINES)) u_ctrl (
        .released (released), .drv_en (ctrl_drv_en));
    bus_drive_group #(.LINES(STAT_LINES)) u_stat (
        .released (released), .drv_en (stat_drv_en));

    assign refresh_hold = freeze;
    assign irq_mask     = freeze;
    assign cpu_stall    = freeze;

    // R8: drivers and acknowledge never disagree
    a_r8_drivers_follow_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_n == (&addr_drv_en) && bus_ack_n == (&data_drv_en)
        && bus_ack_n == (&ctrl_drv_en) && bus_ack_n == (&stat_drv_en)
        && !bus_ack_n == !(|addr_drv_en));

    // R7: while granted, refresh and interrupts are frozen
    a_r7_frozen_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> (refresh_hold && irq_mask && cpu_stall));

endmodule

// File: tb/sim_bus_grant_ctrl.sv
module sim_bus_grant_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AB = 16, DB = 8, CB = 4, SB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req_n = 1'b1;
    logic cyc_last = 1'b0;
    logic bus_ack_n;
    logic [AB-1:0] addr_drv_en;
    logic [DB-1:0] data_drv_en;
    logic [CB-1:0] ctrl_drv_en;
    logic [SB-1:0] stat_drv_en;
    logic refresh_hold, irq_mask, cpu_stall;

    int n_cmp = 0;
    int n_bad = 0;
    int m_phase = 0;   // 0 run, 1 held, 2 handback

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_grant_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .cyc_last(cyc_last),
        .bus_ack_n(bus_ack_n), .addr_drv_en(addr_drv_en), .data_drv_en(data_drv_en),
        .ctrl_drv_en(ctrl_drv_en), .stat_drv_en(stat_drv_en),
        .refresh_hold(refresh_hold), .irq_mask(irq_mask), .cpu_stall(cpu_stall)
    );

    function automatic int next_phase(int ph, logic req_n, logic last);
        if (ph == 0) return (last && !req_n) ? 1 : 0;
        if (ph == 1) return req_n ? 2 : 1;
        return 0;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        logic held;
        logic frz;
        held = (m_phase == 1);
        frz  = (m_phase != 0);
        cmp({tag, " ack"}, bus_ack_n, !held);
        cmp("R8 addr_en", addr_drv_en, held ? 0 : {AB{1'b1}});
        cmp("R8 data_en", data_drv_en, held ? 0 : {DB{1'b1}});
        cmp("R8 ctrl_en", ctrl_drv_en, held ? 0 : {CB{1'b1}});
        cmp("R8 stat_en", stat_drv_en, held ? 0 : {SB{1'b1}});
        cmp("R7 refresh_hold", refresh_hold, frz);
        cmp("R7 irq_mask", irq_mask, frz);
        cmp("R7 cpu_stall", cpu_stall, frz);
    endtask

    // drive at a negedge, model at posedge, check at the following negedge
    task automatic step(logic req_n, logic last, string tag);
        bus_req_n = req_n;
        cyc_last  = last;
        @(posedge clk);
        m_phase = next_phase(m_phase, req_n, last);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_0c1a;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        m_phase = 0;
        check_all("R1 reset");
        rst_n = 1'b1;

        // R3: request away from cycle boundary is ignored
        step(1'b0, 1'b0, "R3 midcycle");
        step(1'b0, 1'b0, "R3 midcycle");
        // R2: boundary grants
        step(1'b0, 1'b1, "R2 grant");
        // R4: held, boundary marker irrelevant
        step(1'b0, 1'b1, "R4 hold");
        step(1'b0, 1'b0, "R4 hold");
        // R5: release coinciding with cycle-last marker
        step(1'b1, 1'b1, "R5 release");
        // R6: new request plus marker during handback is ignored
        step(1'b0, 1'b1, "R6 handback");
        // now running again: same inputs grant
        step(1'b0, 1'b1, "R2 regrant");
        step(1'b1, 1'b0, "R5 release");
        step(1'b1, 1'b0, "R6 resume");
        step(1'b1, 1'b1, "R3 idle");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic rq;
            logic lt;
            rq = ($urandom % 3) != 0 ? bus_req_n : ~bus_req_n;
            lt = ($urandom % 4) == 0;
            step(rq, lt, "R4 random");
        end

        // mid-run reset returns to R1 state
        step(1'b0, 1'b1, "R2 pre-reset");
        rst_n = 1'b0;
        @(posedge clk);
        m_phase = 0;
        @(negedge clk);
        check_all("R1 reset again");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule